// File: doc/BRIEF.md
# USB Start-of-Frame Number Tracker

This block follows the 11-bit frame number that a USB host broadcasts in every start-of-frame (SOF) token, so that isochronous endpoints on the device side have the current frame count. A packet decoder upstream passes in each correctly received SOF as a one-cycle strobe together with its frame number. The tracker stores that number and marks it as trustworthy.

If a token goes missing, a timeout counter detects the gap. It counts pulses of a slow timebase tick, and the limit is a parameter. What happens next depends on a generation flag that software sets through a command strobe. With the flag set, the block makes a stand-in SOF: it advances the frame number, emits a one-cycle pulse and marks the number as provisional. With the flag clear, it marks the number as lost.

Two byte-wide read-only views carry the frame number, the generation flag and the status. A USB bus reset clears the frame state but leaves the flag alone.

Top module: `sof_frame_tracker`

## Requirements
- R1: After reset, both register bytes read 0x00 and the stand-in SOF pulse is low.
- R2: The low byte carries frame bits 6..0 in bit positions 6..0, with bit 7 always 0. The high byte carries frame bits 10..7 in bit positions 7..4, the generation flag in bit 2 and the status in bits 1..0. Bit 3 reads 0.
- R3: A genuine SOF strobe loads the frame number from the token and sets the status to VALID (1) one cycle later, whatever the previous status was. It also wins over a tick in the same cycle.
- R4: The status encoding is BEFORE = 0, VALID = 1, LOST = 2. The value 3 never appears.
- R5: The generation flag changes only in the cycle after a command strobe, when it takes the strobe's enable value. A bus reset does not change it.
- R6: When TIMEOUT_TICKS tick pulses arrive with no genuine SOF, the SOF counts as missed. With the flag clear, the status becomes LOST (2) and no pulse is emitted.
- R7: A missed SOF with the flag set creates a stand-in SOF. The frame number increments modulo 2048 (0x7FF wraps to 0), the status becomes BEFORE (0), and the pulse output is high for exactly one cycle.
- R8: A genuine SOF restarts the timeout count, so fewer than TIMEOUT_TICKS ticks after it never trigger a missed-SOF event.
- R9: A bus reset sets the frame number and status to 0 and clears the timeout count. It takes priority over a genuine SOF in the same cycle.
- R10: Successive stand-in SOFs keep the status at BEFORE and keep advancing the frame number until a genuine SOF arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_valid_i | input | 1 | One-cycle strobe for a correctly received SOF token |
| sof_frame_i | input | 11 | Frame number carried by the token |
| tick_i | input | 1 | Timebase pulse used for the missed-SOF timeout |
| bus_reset_i | input | 1 | USB bus reset pulse |
| cmd_wr_i | input | 1 | Command strobe that updates the generation flag |
| cmd_gen_en_i | input | 1 | New generation flag value, taken when cmd_wr_i is high |
| frame_lo_o | output | 8 | Low register byte |
| frame_hi_o | output | 8 | High register byte |
| sof_pulse_o | output | 1 | One-cycle pulse for each stand-in SOF |

## Verification
The hardest case to reach is a chain of stand-in SOFs that starts at frame 0x7FF and crosses the modulo-2048 wrap. Reaching it needs a genuine SOF carrying 0x7FF, then an exact count of ticks with no token, then another full run of ticks for the second stand-in SOF. The bench shortens the timeout to four ticks and places each tick by hand. It then checks the cycles just before and at the expiry, the genuine SOF that arrives together with a tick, and a bus reset in the same cycle as a token.

// File: rtl/sof_frame_tracker.sv
module sof_frame_tracker #(
  parameter int TIMEOUT_TICKS = 1010,
  parameter int FRAME_W       = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_valid_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic               tick_i,
  input  logic               bus_reset_i,
  input  logic               cmd_wr_i,
  input  logic               cmd_gen_en_i,
  output logic [7:0]         frame_lo_o,
  output logic [7:0]         frame_hi_o,
  output logic               sof_pulse_o
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [1:0] ST_BEFORE = 2'd0, ST_VALID = 2'd1, ST_LOST = 2'd2;

  logic [FRAME_W-1:0] frame_q;
  logic [1:0]         state_q;
  logic               gen_en_q;
  logic [CNT_W-1:0]   cnt_q;

  wire expire = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gen_en_q <= 1'b0;
    else if (cmd_wr_i) gen_en_q <= cmd_gen_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q     <= '0;
      state_q     <= ST_BEFORE;
      cnt_q       <= '0;
      sof_pulse_o <= 1'b0;
    end else begin
      sof_pulse_o <= 1'b0;
      if (bus_reset_i) begin
        frame_q <= '0;
        state_q <= ST_BEFORE;
        cnt_q   <= '0;
      end else if (sof_valid_i) begin
        frame_q <= sof_frame_i;
        state_q <= ST_VALID;
        cnt_q   <= '0;
      end else if (expire) begin
        cnt_q <= '0;
        if (gen_en_q) begin
          frame_q     <= frame_q + 1'b1;
          state_q     <= ST_BEFORE;
          sof_pulse_o <= 1'b1;
        end else begin
          state_q <= ST_LOST;
        end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign frame_lo_o = {1'b0, frame_q[6:0]};
  assign frame_hi_o = {frame_q[10:7], 1'b0, gen_en_q, state_q};
endmodule

// File: rtl/sof_frame_tracker_chk.sv
module sof_frame_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sof_valid_i,
  input logic [10:0] sof_frame_i,
  input logic        bus_reset_i,
  input logic        cmd_wr_i,
  input logic        cmd_gen_en_i,
  input logic [7:0]  frame_lo_o,
  input logic [7:0]  frame_hi_o,
  input logic        sof_pulse_o
);
  wire [10:0] fr = {frame_hi_o[7:4], frame_lo_o[6:0]};

  assert_fixed_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lo_o[7] == 1'b0 && frame_hi_o[3] == 1'b0);

  assert_no_status3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hi_o[1:0] != 2'd3);

  assert_genuine_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_valid_i && !bus_reset_i) |=> (fr == $past(sof_frame_i) && frame_hi_o[1:0] == 2'd1));

  assert_flag_by_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_i |=> frame_hi_o[2] == $past(cmd_gen_en_i));

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr_i |=> $stable(frame_hi_o[2]));

  assert_standin_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_pulse_o ##1 sof_pulse_o |-> (fr == $past(fr) + 11'd1 && frame_hi_o[1:0] == 2'd0 && frame_hi_o[2]));

  assert_bus_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> (fr == 11'd0 && frame_hi_o[1:0] == 2'd0 && !sof_pulse_o));
endmodule

bind sof_frame_tracker sof_frame_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof_valid_i(sof_valid_i), .sof_frame_i(sof_frame_i),
  .bus_reset_i(bus_reset_i), .cmd_wr_i(cmd_wr_i), .cmd_gen_en_i(cmd_gen_en_i),
  .frame_lo_o(frame_lo_o), .frame_hi_o(frame_hi_o), .sof_pulse_o(sof_pulse_o));

// File: tb/test_sof_frame_tracker.sv
module test_sof_frame_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sof_valid_i = 0, tick_i = 0, bus_reset_i = 0, cmd_wr_i = 0, cmd_gen_en_i = 0;
  logic [10:0] sof_frame_i = '0;
  logic [7:0] frame_lo_o, frame_hi_o;
  logic sof_pulse_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sof_frame_tracker #(.TIMEOUT_TICKS(4)) i_sof_frame_tracker (
    .clk(clk), .rst_n(rst_n), .sof_valid_i(sof_valid_i), .sof_frame_i(sof_frame_i),
    .tick_i(tick_i), .bus_reset_i(bus_reset_i), .cmd_wr_i(cmd_wr_i),
    .cmd_gen_en_i(cmd_gen_en_i), .frame_lo_o(frame_lo_o), .frame_hi_o(frame_hi_o),
    .sof_pulse_o(sof_pulse_o));

  typedef struct {
    string      req;
    logic [10:0] frame;
    bit         chk_frame;
    logic       en;
    logic [1:0] st;
    logic       pulse;
  } exp_t;
  exp_t q[$];

  task automatic step(input bit sof, input logic [10:0] fin, input bit tk, input bit br,
                      input bit wr, input bit en_in, input logic [10:0] ef, input bit cf,
                      input bit een, input logic [1:0] est, input bit ep, input string req);
    exp_t e;
    @(negedge clk);
    sof_valid_i = sof; sof_frame_i = fin; tick_i = tk; bus_reset_i = br;
    cmd_wr_i = wr; cmd_gen_en_i = en_in;
    e.req = req; e.frame = ef; e.chk_frame = cf; e.en = een; e.st = est; e.pulse = ep;
    q.push_back(e);
  endtask

  task automatic ticks(input int n, input logic [10:0] ef, input bit cf, input bit een,
                       input logic [1:0] est, input string req);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, 0, ef, cf, een, est, 0, req);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      logic [7:0] elo, ehi;
      e = q.pop_front();
      elo = {1'b0, e.frame[6:0]};
      ehi = {e.frame[10:7], 1'b0, e.en, e.st};
      tests++;
      if ((e.chk_frame ? (frame_lo_o != elo || frame_hi_o != ehi)
                       : (frame_hi_o[3:0] != ehi[3:0] || frame_lo_o[7] != 1'b0))
          || sof_pulse_o != e.pulse) begin
        fails++;
        $display("FAIL %s: lo=%h hi=%h pulse=%b expected lo=%h hi=%h pulse=%b",
                 e.req, frame_lo_o, frame_hi_o, sof_pulse_o, elo, ehi, e.pulse);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (frame_lo_o !== 8'h00 || frame_hi_o !== 8'h00 || sof_pulse_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: lo=%h hi=%h pulse=%b expected 00 00 0", frame_lo_o, frame_hi_o, sof_pulse_o);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 11'h000, 1, 0, 2'd0, 0, "R1 idle after reset");
    step(1, 11'h5A3, 0, 0, 0, 0, 11'h5A3, 1, 0, 2'd1, 0, "R2 R3 genuine SOF layout");
    ticks(3, 11'h5A3, 1, 0, 2'd1, "R6 below timeout");
    step(0, 0, 1, 0, 0, 0, 11'h000, 0, 0, 2'd2, 0, "R6 R4 missed SOF gives LOST");
    step(0, 0, 0, 0, 1, 1, 11'h000, 0, 1, 2'd2, 0, "R5 command sets flag");
    step(1, 11'h7FF, 0, 0, 0, 0, 11'h7FF, 1, 1, 2'd1, 0, "R3 LOST to VALID");
    ticks(3, 11'h7FF, 1, 1, 2'd1, "R8 below timeout");
    step(0, 0, 1, 0, 0, 0, 11'h000, 1, 1, 2'd0, 1, "R7 stand-in SOF wraps");
    step(0, 0, 0, 0, 0, 0, 11'h000, 1, 1, 2'd0, 0, "R7 pulse one cycle");
    ticks(3, 11'h000, 1, 1, 2'd0, "R10 waiting");
    step(0, 0, 1, 0, 0, 0, 11'h001, 1, 1, 2'd0, 1, "R10 second stand-in SOF");
    step(1, 11'h010, 1, 0, 0, 0, 11'h010, 1, 1, 2'd1, 0, "R3 SOF beats tick");
    ticks(3, 11'h010, 1, 1, 2'd1, "R8 count from SOF");
    step(1, 11'h011, 0, 0, 0, 0, 11'h011, 1, 1, 2'd1, 0, "R8 SOF restarts count");
    ticks(3, 11'h011, 1, 1, 2'd1, "R8 no event after restart");
    step(1, 11'h333, 0, 1, 0, 0, 11'h000, 1, 1, 2'd0, 0, "R9 R5 bus reset wins, flag kept");
    ticks(3, 11'h000, 1, 1, 2'd0, "R9 counter cleared");
    step(0, 0, 1, 0, 0, 0, 11'h001, 1, 1, 2'd0, 1, "R9 R7 stand-in after reset");
    step(0, 0, 0, 0, 1, 0, 11'h001, 1, 0, 2'd0, 0, "R5 command clears flag");
    ticks(3, 11'h001, 1, 0, 2'd0, "R6 waiting");
    step(0, 0, 1, 0, 0, 0, 11'h000, 0, 0, 2'd2, 0, "R6 LOST without pulse");
    step(0, 0, 0, 1, 0, 0, 11'h000, 1, 0, 2'd0, 0, "R9 bus reset clears LOST");
    @(negedge clk);
    sof_valid_i = 0; tick_i = 0; bus_reset_i = 0; cmd_wr_i = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule